// File: doc/BRIEF.md
# Fibonacci Sequencer Control FSM

This block is the control unit of a small register-file datapath that produces Fibonacci terms. It watches two inputs, a start request and a zero flag returned by the datapath (high when the count register holds zero). On every cycle it drives one control word: a write address, a write enable, a select that routes the external count into the register file, two read addresses and a 3-bit operation code. The state register is one-hot, with one flip-flop per step.

After reset the controller waits in an idle state. A start request moves it to the count-load step. That step repeats for as long as start stays high, so the count is reloaded every cycle until start is released. It then seeds two working registers with 1 and writes the count to data memory. Next it enters a five-step loop: copy the older term to a temporary register, add, move the temporary value back, decrement the count, and store the newest term. At each store step the zero flag decides whether to run the loop again or to return to idle. A single-cycle done pulse marks the exit.

With a 4-bit datapath and a count of N (N of 0 means 16 passes), memory receives the count, then F(3) through F(N+2) modulo 16.

Top module: `fib_seq_ctrl`

## Requirements
- R1: The state vector has exactly one bit set on every cycle after reset. A synchronous active-high `rst` returns it to the idle state alone, whatever step it was in. In idle the control word is all zero (`wr_en`=0, `ld_sel`=0, addresses 0, `op_code`=000) and `done`=0.
- R2: In idle the controller stays idle while `start` is low. It moves to the count-load step on the first clock edge that sees `start` high.
- R3: The count-load step drives `wr_en`=1, `ld_sel`=1, `wr_addr`=0, `op_code`=100. It repeats on every edge where `start` is still high and advances only on the first edge with `start` low.
- R4: After the count-load step, initialisation runs in this order. Register 1 gets 1 (`wr_en`=1, `wr_addr`=1, `op_code`=001). Register 2 gets 1 (`wr_en`=1, `wr_addr`=2, `op_code`=001). Register 0 is stored to memory (`wr_en`=0, `rd_addr_a`=0, `op_code`=101).
- R5: The loop steps are, in order:
  - copy to temp: `wr_addr`=3, `rd_addr_a`=1, op 111
  - add: `wr_addr`=1, `rd_addr_a`=1, `rd_addr_b`=2, op 110
  - move temp back: `wr_addr`=2, `rd_addr_a`=3, op 111
  - decrement: `wr_addr`=0, `rd_addr_a`=0, op 011
  - store: `wr_en`=0, `rd_addr_a`=1, op 101

  The first four steps have `wr_en`=1. Op 111 passes operand A, op 110 adds A and B, op 011 is A minus 1, op 001 gives 1 and op 101 writes operand A to memory. Read addresses not listed are 0.
- R6: In the store step of the loop, `zero_flag` high returns the controller to idle on the next edge. `zero_flag` low sends it back to the copy-to-temp step.
- R7: `done` is high for exactly one cycle: the first idle cycle after the loop exits. It is low at all other times.
- R8: `wr_en` is low whenever `op_code` is 101. `ld_sel` is high only in the count-load step.
- R9: Paired with a 4-bit datapath, a run with count N stores the count and then F(3)..F(N+2) modulo 16 (16 passes for N=0). `done` appears 4+5N cycles after the first edge that sees `start` low (N≥1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request; held high keeps reloading the count |
| zero_flag | input | 1 | High when the datapath count register is zero |
| wr_addr | output | 2 | Register-file write address |
| wr_en | output | 1 | Register-file write enable |
| ld_sel | output | 1 | Selects the external count as write data |
| rd_addr_a | output | 2 | Read address for ALU operand A / store data |
| rd_addr_b | output | 2 | Read address for ALU operand B |
| op_code | output | 3 | Operation code of the current step |
| done | output | 1 | One-cycle pulse after the loop exits |

## Verification
The assertions check on every cycle that the state vector stays one-hot and that idle holds without a request. They also check that the load step repeats while start is held, that a store never coincides with a register write, that the exit branch lands in idle with done raised, and that done never lasts two cycles. The bench scenarios cover what needs a datapath model and a sense of time. These are the exact order of control words through initialisation and a loop pass, the branch back when the zero flag is low, the stored Fibonacci terms for several counts (including wrap-around and a zero count), the cycle latency to done, and a reset issued in mid-run.

// File: rtl/fib_ctrl_pkg.sv
package fib_ctrl_pkg;

    localparam int REG_AW = 2;
    localparam int OP_W   = 3;
    localparam int N_ST   = 10;

    // one-hot bit positions
    localparam int S_IDLE  = 0;
    localparam int S_LDCNT = 1;
    localparam int S_SET1  = 2;
    localparam int S_SET2  = 3;
    localparam int S_STCNT = 4;
    localparam int S_CPTMP = 5;
    localparam int S_ADD   = 6;
    localparam int S_MOVT  = 7;
    localparam int S_DEC   = 8;
    localparam int S_STNUM = 9;

    typedef logic [N_ST-1:0] onehot_t;

    localparam onehot_t IDLE_VEC = onehot_t'(1) << S_IDLE;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'b000,
        OP_ONE   = 3'b001,
        OP_DEC   = 3'b011,
        OP_LOAD  = 3'b100,
        OP_STORE = 3'b101,
        OP_ADD   = 3'b110,
        OP_PASS  = 3'b111
    } op_e;

    typedef struct packed {
        logic              wr_en;
        logic              ld_sel;
        logic [REG_AW-1:0] wr_addr;
        logic [REG_AW-1:0] rd_a;
        logic [REG_AW-1:0] rd_b;
        op_e               op;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{1'b0, 1'b0, 2'd0, 2'd0, 2'd0, OP_NOP};

    function automatic ctl_t mk_ctl(input logic we, input logic ls,
                                    input logic [REG_AW-1:0] wa,
                                    input logic [REG_AW-1:0] ra,
                                    input logic [REG_AW-1:0] rb,
                                    input op_e o);
        ctl_t c;
        c.wr_en   = we;
        c.ld_sel  = ls;
        c.wr_addr = wa;
        c.rd_a    = ra;
        c.rd_b    = rb;
        c.op      = o;
        return c;
    endfunction

    // control word of each step, indexed by one-hot bit position
    function automatic ctl_t step_word(input int idx);
        case (idx)
            S_LDCNT: return mk_ctl(1'b1, 1'b1, 2'd0, 2'd0, 2'd0, OP_LOAD);
            S_SET1:  return mk_ctl(1'b1, 1'b0, 2'd1, 2'd0, 2'd0, OP_ONE);
            S_SET2:  return mk_ctl(1'b1, 1'b0, 2'd2, 2'd0, 2'd0, OP_ONE);
            S_STCNT: return mk_ctl(1'b0, 1'b0, 2'd0, 2'd0, 2'd0, OP_STORE);
            S_CPTMP: return mk_ctl(1'b1, 1'b0, 2'd3, 2'd1, 2'd0, OP_PASS);
            S_ADD:   return mk_ctl(1'b1, 1'b0, 2'd1, 2'd1, 2'd2, OP_ADD);
            S_MOVT:  return mk_ctl(1'b1, 1'b0, 2'd2, 2'd3, 2'd0, OP_PASS);
            S_DEC:   return mk_ctl(1'b1, 1'b0, 2'd0, 2'd0, 2'd0, OP_DEC);
            S_STNUM: return mk_ctl(1'b0, 1'b0, 2'd0, 2'd1, 2'd0, OP_STORE);
            default: return CTL_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/fib_next_state.sv
module fib_next_state
    import fib_ctrl_pkg::*;
(
    input  onehot_t cur,
    input  logic    start,
    input  logic    zero_flag,
    output onehot_t nxt,
    output logic    exit_loop
);
    always_comb begin
        exit_loop      = cur[S_STNUM] & zero_flag;
        nxt            = '0;
        nxt[S_IDLE]    = (cur[S_IDLE] & ~start) | exit_loop;
        nxt[S_LDCNT]   = (cur[S_IDLE] | cur[S_LDCNT]) & start;
        nxt[S_SET1]    = cur[S_LDCNT] & ~start;
        nxt[S_SET2]    = cur[S_SET1];
        nxt[S_STCNT]   = cur[S_SET2];
        nxt[S_CPTMP]   = cur[S_STCNT] | (cur[S_STNUM] & ~zero_flag);
        nxt[S_ADD]     = cur[S_CPTMP];
        nxt[S_MOVT]    = cur[S_ADD];
        nxt[S_DEC]     = cur[S_MOVT];
        nxt[S_STNUM]   = cur[S_DEC];
    end
endmodule

// File: rtl/fib_ctl_decode.sv
module fib_ctl_decode
    import fib_ctrl_pkg::*;
(
    input  onehot_t cur,
    output ctl_t    ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        for (int i = 0; i < N_ST; i++) begin
            if (cur[i]) ctl = ctl | step_word(i);
        end
    end
endmodule

// File: rtl/fib_seq_ctrl.sv
module fib_seq_ctrl
    import fib_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              zero_flag,
    output logic [REG_AW-1:0] wr_addr,
    output logic              wr_en,
    output logic              ld_sel,
    output logic [REG_AW-1:0] rd_addr_a,
    output logic [REG_AW-1:0] rd_addr_b,
    output logic [OP_W-1:0]   op_code,
    output logic              done
);
    onehot_t st_q;
    onehot_t st_d;
    logic    exit_loop;
    ctl_t    ctl;

    fib_next_state u_next (
        .cur       (st_q),
        .start     (start),
        .zero_flag (zero_flag),
        .nxt       (st_d),
        .exit_loop (exit_loop)
    );

    // one D flip-flop per state, idle bit presets on reset
    for (genvar gi = 0; gi < N_ST; gi++) begin : g_state_ff
        always_ff @(posedge clk) begin
            if (rst) st_q[gi] <= IDLE_VEC[gi];
            else     st_q[gi] <= st_d[gi];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= exit_loop;
    end

    fib_ctl_decode u_dec (
        .cur (st_q),
        .ctl (ctl)
    );

    assign wr_addr   = ctl.wr_addr;
    assign wr_en     = ctl.wr_en;
    assign ld_sel    = ctl.ld_sel;
    assign rd_addr_a = ctl.rd_a;
    assign rd_addr_b = ctl.rd_b;
    assign op_code   = ctl.op;

    // R1
    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);
    // R2
    p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q[S_IDLE] && !start) |=> (st_q[S_IDLE] && !wr_en));
    // R3
    p_load_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q[S_LDCNT] && start) |=> (ld_sel && op_code == OP_LOAD));
    // R6
    p_exit_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_STORE && rd_addr_a == 2'd1 && zero_flag) |=> (st_q[S_IDLE] && done));
    // R7
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    p_store_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_STORE) |-> !wr_en);
endmodule

// File: tb/test_fib_seq_ctrl.sv
`timescale 1ns/1ps
module test_fib_seq_ctrl;
    import fib_ctrl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic zero_flag;
    logic [1:0] wr_addr, rd_addr_a, rd_addr_b;
    logic wr_en, ld_sel, done;
    logic [2:0] op_code;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    fib_seq_ctrl i_fib_seq_ctrl (
        .clk(clk), .rst(rst), .start(start), .zero_flag(zero_flag),
        .wr_addr(wr_addr), .wr_en(wr_en), .ld_sel(ld_sel),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .op_code(op_code), .done(done)
    );

    // behavioural 4-bit datapath
    logic [3:0] rf [4];
    logic [3:0] mem [32];
    logic [3:0] count_in = 4'd0;
    logic       mem_clr = 1'b0;
    int         n_st;

    function automatic logic [3:0] alu(input logic [2:0] o, input logic [3:0] a, input logic [3:0] b);
        case (o)
            3'b001:  return 4'd1;
            3'b111:  return a;
            3'b110:  return a + b;
            3'b011:  return a - 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    assign zero_flag = (rf[0] == 4'd0);

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) rf[k] <= 4'd0;
            n_st <= 0;
        end else begin
            if (mem_clr) n_st <= 0;
            if (wr_en)
                rf[wr_addr] <= ld_sel ? count_in : alu(op_code, rf[rd_addr_a], rf[rd_addr_b]);
            if (op_code == 3'b101 && !wr_en) begin
                mem[n_st[4:0]] <= rf[rd_addr_a];
                n_st <= n_st + 1;
            end
        end
    end

    function automatic logic [3:0] fib(input int k);
        logic [3:0] a = 4'd1, b = 4'd1, t;
        for (int i = 3; i <= k; i++) begin
            t = a + b; a = b; b = t;
        end
        return b;
    endfunction

    function automatic logic [10:0] word_now();
        return {wr_en, ld_sel, wr_addr, rd_addr_a, rd_addr_b, op_code};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    localparam logic [10:0] W_IDLE  = 11'b0_0_00_00_00_000;
    localparam logic [10:0] W_LDCNT = 11'b1_1_00_00_00_100;
    localparam logic [10:0] W_SET1  = 11'b1_0_01_00_00_001;
    localparam logic [10:0] W_SET2  = 11'b1_0_10_00_00_001;
    localparam logic [10:0] W_STCNT = 11'b0_0_00_00_00_101;
    localparam logic [10:0] W_CPTMP = 11'b1_0_11_01_00_111;
    localparam logic [10:0] W_ADD   = 11'b1_0_01_01_10_110;
    localparam logic [10:0] W_MOVT  = 11'b1_0_10_11_00_111;
    localparam logic [10:0] W_DEC   = 11'b1_0_00_00_00_011;
    localparam logic [10:0] W_STNUM = 11'b0_0_00_01_00_101;

    // vector table: count, start hold cycles
    localparam int N_VEC = 6;
    localparam int VEC_CNT  [N_VEC] = '{1, 2, 3, 5, 9, 0};
    localparam int VEC_HOLD [N_VEC] = '{1, 3, 1, 2, 1, 4};

    task automatic run_count(input int cnt, input int hold);
        int cyc;
        int iters;
        logic bad_r8;
        iters = (cnt == 0) ? 16 : cnt;
        @(negedge clk);
        count_in = cnt[3:0]; start = 1'b1; mem_clr = 1'b1;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(word_now() == W_LDCNT, "R3 load step held", word_now(), W_LDCNT);
        end
        mem_clr = 1'b0; start = 1'b0; cyc = 0; bad_r8 = 1'b0;
        while (!done && cyc < 400) begin
            @(posedge clk); @(negedge clk); cyc++;
            if ((op_code == 3'b101 && wr_en) || (ld_sel && op_code != 3'b100)) bad_r8 = 1'b1;
        end
        chk(!bad_r8, "R8 store without write, select only in load", bad_r8, 0);
        if (cnt != 0) chk(cyc == 4 + 5*cnt, "R9 latency to done", cyc, 4 + 5*cnt);
        chk(n_st == iters + 1, "R9 store count", n_st, iters + 1);
        chk(mem[0] == cnt[3:0], "R9 stored count", mem[0], cnt[3:0]);
        for (int i = 1; i <= iters; i++)
            chk(mem[i] == fib(i + 2), "R9 stored term", mem[i], fib(i + 2));
        @(negedge clk);
        chk(!done && word_now() == W_IDLE, "R7 done single cycle", {done, word_now()}, 0);
    endtask

    task automatic expect_word(input logic [10:0] w, input string req);
        @(negedge clk);
        chk(word_now() == w, req, word_now(), w);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(word_now() == W_IDLE && !done, "R1 reset state", word_now(), W_IDLE);
        // R2 idle holds while start low
        repeat (5) @(negedge clk);
        chk(word_now() == W_IDLE, "R2 idle waits", word_now(), W_IDLE);
        // R2 start moves to load step on the next edge
        start = 1'b1; count_in = 4'd2; mem_clr = 1'b1;
        expect_word(W_LDCNT, "R2 start enters load");
        expect_word(W_LDCNT, "R3 reload while start high");
        start = 1'b0; mem_clr = 1'b0;
        expect_word(W_SET1,  "R4 set register 1");
        expect_word(W_SET2,  "R4 set register 2");
        expect_word(W_STCNT, "R4 store count");
        expect_word(W_CPTMP, "R5 copy to temp");
        expect_word(W_ADD,   "R5 add");
        expect_word(W_MOVT,  "R5 move temp back");
        expect_word(W_DEC,   "R5 decrement");
        expect_word(W_STNUM, "R5 store term");
        chk(!zero_flag, "R6 count not yet zero", zero_flag, 0);
        expect_word(W_CPTMP, "R6 loop back on zero low");
        expect_word(W_ADD,   "R5 add second pass");
        expect_word(W_MOVT,  "R5 move second pass");
        expect_word(W_DEC,   "R5 dec second pass");
        expect_word(W_STNUM, "R5 store second pass");
        @(negedge clk);
        chk(done && word_now() == W_IDLE, "R6 R7 exit to idle with done", {done, word_now()}, {1'b1, W_IDLE});
        @(negedge clk);
        chk(!done, "R7 done drops", done, 0);
        chk(mem[1] == 4'd2 && mem[2] == 4'd3, "R9 short run terms", {mem[1], mem[2]}, 8'h23);

        // vector table walk
        for (int v = 0; v < N_VEC; v++) run_count(VEC_CNT[v], VEC_HOLD[v]);

        // R1 reset in mid-run
        @(negedge clk);
        start = 1'b1; count_in = 4'd7;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(word_now() == W_IDLE && !done, "R1 mid-run reset", word_now(), W_IDLE);
        repeat (3) @(negedge clk);
        chk(word_now() == W_IDLE, "R2 stays idle after reset", word_now(), W_IDLE);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule